// File: doc/BRIEF.md
# Stop-Clock Throttling Controller

This block paces a processor (or two processors sharing one line) by toggling an active-low stop-clock request. While throttling is enabled the request alternates between an asserted (low) phase and a negated (high) phase. A single down-counter times both phases. It is loaded from the programmed low-time value when the request asserts, and from the programmed high-time value when the request negates.

The asserted-phase count can be made to wait for the processor to acknowledge the request with a stop-grant bus cycle, which arrives here as a one-cycle pulse. A second mode bit sets how many grant pulses release the count: one, or two when both processors on the shared line must acknowledge. A break-event pulse ends an asserted phase early. During a negated phase it restarts the high-time count. The timing values and mode bits are plain input ports, driven by the register file that owns them.

Top module: `clk_stop_throttle`

## Requirements
- R1: After reset the request `stop_req_no` is high (negated) and the controller is idle.
- R2: While `enable_i` is 0, `stop_req_no` is high from the next clock on, whatever the other inputs do.
- R3: With `wait_grant_i`=0, the cycle after `enable_i` is first seen high the request goes low and stays low for exactly max(`low_time_i`,1) cycles. Grant pulses have no effect on that count.
- R4: A negated phase lasts max(`high_time_i`,1) cycles. The request then goes low again for a fresh max(`low_time_i`,1) cycles, and the two phases repeat.
- R5: With `wait_grant_i`=1, the request stays low and the low-time count does not advance until the releasing grant pulse is seen. From the cycle after that pulse the request stays low for max(`low_time_i`,1) more cycles.
- R6: With `dual_grant_i`=0 (single-grant mode), the first grant pulse releases the count. Any further grant pulse in the same asserted phase is ignored, and the phase length is unchanged.
- R7: With `dual_grant_i`=1 and `wait_grant_i`=1, the count is released only by the second grant pulse of the asserted phase.
- R8: A break pulse while the request is low drives it high on the next clock. The following negated phase lasts max(`high_time_i`,1) cycles.
- R9: A break pulse while the request is high reloads the high-time value. The negated phase then lasts max(`high_time_i`,1) cycles counted from the cycle after the break.
- R10: A time value of 0 gives a phase of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Throttling enable |
| wait_grant_i | input | 1 | 1: asserted-phase count waits for stop grant |
| dual_grant_i | input | 1 | 1: two grant pulses release the count; 0: the first grant does |
| grant_i | input | 1 | One-cycle pulse per stop-grant bus cycle |
| break_i | input | 1 | One-cycle break-event pulse |
| low_time_i | input | TW | Asserted-phase length in cycles (0 means 1) |
| high_time_i | input | TW | Negated-phase length in cycles (0 means 1) |
| stop_req_no | output | 1 | Stop-clock request, active low |

## Verification
The hardest situation to reach from the ports is a break or grant pulse that lands in the middle of a running phase. Such a pulse must act on the timer partway through a count, not at a phase boundary. The bench drives each pulse from inside the loop that counts the low or high samples, at a chosen sample index, so the expected phase length follows from that index and the programmed time. The table loop covers plain periodic throttling with zero, short and long times. The directed tests then place second grants, dual-grant releases and breaks in both phases.

// File: rtl/clk_stop_throttle_pkg.sv
package clk_stop_throttle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_AWAIT = 2'd1,  // request low, waiting for grant
    ST_ACNT  = 2'd2,  // request low, counting
    ST_NEG   = 2'd3   // request high, counting
  } thr_state_e;
endpackage

// File: rtl/thr_phase_timer.sv
module thr_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          count_i,
  output logic          done_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ONE;
    end else if (load_i) begin
      cnt_q <= (load_val_i == '0) ? ONE : load_val_i;
    end else if (count_i && cnt_q > ONE) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign done_o = (cnt_q == ONE);
endmodule

// File: rtl/thr_grant_gate.sv
module thr_grant_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic grant_i,
  input  logic dual_i,
  output logic release_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (!arm_i)  seen_q <= 1'b0;
    else if (grant_i) seen_q <= 1'b1;
  end

  assign release_o = arm_i & grant_i & (~dual_i | seen_q);
endmodule

// File: rtl/clk_stop_throttle.sv
module clk_stop_throttle
  import clk_stop_throttle_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          wait_grant_i,
  input  logic          dual_grant_i,
  input  logic          grant_i,
  input  logic          break_i,
  input  logic [TW-1:0] low_time_i,
  input  logic [TW-1:0] high_time_i,
  output logic          stop_req_no
);
  thr_state_e state_q, state_d;
  logic load, load_hi, done, release_cnt, counting;
  logic [TW-1:0] load_val;

  thr_grant_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (state_q == ST_AWAIT),
    .grant_i   (grant_i),
    .dual_i    (dual_grant_i),
    .release_o (release_cnt)
  );

  assign counting = (state_q == ST_ACNT) || (state_q == ST_NEG);
  assign load_val = load_hi ? high_time_i : low_time_i;

  thr_phase_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .count_i    (counting),
    .done_o     (done)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    load_hi = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = wait_grant_i ? ST_AWAIT : ST_ACNT;
          load    = 1'b1;
        end
        ST_AWAIT: begin
          if (break_i) begin
            state_d = ST_NEG;
            load    = 1'b1;
            load_hi = 1'b1;
          end else if (release_cnt) begin
            state_d = ST_ACNT;  // timer already holds low time
          end
        end
        ST_ACNT: begin
          if (break_i || done) begin
            state_d = ST_NEG;
            load    = 1'b1;
            load_hi = 1'b1;
          end
        end
        ST_NEG: begin
          if (break_i) begin
            load    = 1'b1;
            load_hi = 1'b1;
          end else if (done) begin
            state_d = wait_grant_i ? ST_AWAIT : ST_ACNT;
            load    = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign stop_req_no = !((state_q == ST_AWAIT) || (state_q == ST_ACNT));
endmodule

// File: rtl/clk_stop_throttle_chk.sv
module clk_stop_throttle_chk
  import clk_stop_throttle_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       grant_i,
  input logic       break_i,
  input logic       stop_req_no,
  input thr_state_e state_i
);
  a_r1_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(stop_req_no));

  a_r2_disable_negates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> stop_req_no);

  a_r3_enable_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && state_i == ST_IDLE |=> !stop_req_no);

  a_r5_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && state_i == ST_AWAIT && !grant_i && !break_i
      |=> !stop_req_no && state_i == ST_AWAIT);

  a_r8_break_negates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && break_i && !stop_req_no |=> stop_req_no);
endmodule

bind clk_stop_throttle clk_stop_throttle_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .grant_i     (grant_i),
  .break_i     (break_i),
  .stop_req_no (stop_req_no),
  .state_i     (state_q)
);

// File: tb/sim_clk_stop_throttle.sv
`timescale 1ns/1ps
module sim_clk_stop_throttle;
  localparam int TW = 8;
  localparam int CAP = 1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, wait_grant_i = 1'b0, dual_grant_i = 1'b0;
  logic grant_i = 1'b0, break_i = 1'b0;
  logic [TW-1:0] low_time_i = '0, high_time_i = '0;
  logic stop_req_no;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_stop_throttle #(.TW(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
    .wait_grant_i(wait_grant_i), .dual_grant_i(dual_grant_i),
    .grant_i(grant_i), .break_i(break_i),
    .low_time_i(low_time_i), .high_time_i(high_time_i),
    .stop_req_no(stop_req_no)
  );

  // {low_time, high_time}
  localparam logic [15:0] VEC [6] = '{
    {8'd3, 8'd4}, {8'd1, 8'd1}, {8'd0, 8'd0},
    {8'd7, 8'd2}, {8'd0, 8'd5}, {8'd20, 8'd0}
  };

  function automatic int eff(input logic [TW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (stop_req_no == lvl && n < CAP) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic [TW-1:0] lo, input logic [TW-1:0] hi,
                         input logic wg, input logic dg);
    enable_i = 1'b0;
    repeat (2) @(negedge clk);
    low_time_i = lo; high_time_i = hi; wait_grant_i = wg; dual_grant_i = dg;
    enable_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset level", int'(stop_req_no), 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle while disabled", int'(stop_req_no), 1);

    // table: periodic throttling, no wait
    foreach (VEC[i]) begin
      restart(VEC[i][15:8], VEC[i][7:0], 1'b0, 1'b0);
      count_level(1'b0, n);
      check("R3/R10 first low phase", n, eff(VEC[i][15:8]));
      count_level(1'b1, n);
      check("R4/R10 high phase", n, eff(VEC[i][7:0]));
      count_level(1'b0, n);
      check("R4 reasserted low phase", n, eff(VEC[i][15:8]));
    end

    // R3: grants ignored without wait mode
    restart(8'd5, 8'd3, 1'b0, 1'b0);
    n = 0;
    while (stop_req_no == 1'b0 && n < CAP) begin
      grant_i = (n == 1);
      n++;
      @(negedge clk);
    end
    grant_i = 1'b0;
    check("R3 grant ignored no-wait", n, 5);

    // R5: wait mode holds low until grant
    restart(8'd4, 8'd3, 1'b1, 1'b0);
    repeat (6) @(negedge clk);
    check("R5 held low awaiting grant", int'(stop_req_no), 0);
    grant_i = 1'b1; @(negedge clk); grant_i = 1'b0;
    count_level(1'b0, n);
    check("R5 low after grant", n, 4);

    // R6: second grant ignored in single-grant mode
    restart(8'd5, 8'd3, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    grant_i = 1'b1; @(negedge clk); grant_i = 1'b0;
    n = 0;
    while (stop_req_no == 1'b0 && n < CAP) begin
      grant_i = (n == 2);
      n++;
      @(negedge clk);
    end
    grant_i = 1'b0;
    check("R6 second grant ignored", n, 5);

    // R7: dual mode needs two grants
    restart(8'd3, 8'd3, 1'b1, 1'b1);
    grant_i = 1'b1; @(negedge clk); grant_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 held after first grant", int'(stop_req_no), 0);
    grant_i = 1'b1; @(negedge clk); grant_i = 1'b0;
    count_level(1'b0, n);
    check("R7 low after second grant", n, 3);

    // R8: break while asserted
    restart(8'd10, 8'd6, 1'b0, 1'b0);
    n = 0;
    while (stop_req_no == 1'b0 && n < CAP) begin
      break_i = (n == 3);
      n++;
      @(negedge clk);
    end
    break_i = 1'b0;
    check("R8 low cut by break", n, 4);
    count_level(1'b1, n);
    check("R8 high after break", n, 6);

    // R9: break while negated restarts high count
    restart(8'd2, 8'd6, 1'b0, 1'b0);
    count_level(1'b0, n);
    n = 0;
    while (stop_req_no == 1'b1 && n < CAP) begin
      break_i = (n == 2);
      n++;
      @(negedge clk);
    end
    break_i = 1'b0;
    check("R9 high restarted by break", n, 9);

    // R2: disable mid low phase
    restart(8'd20, 8'd2, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    enable_i = 1'b0;
    @(negedge clk);
    check("R2 disable negates", int'(stop_req_no), 1);
    n = 0;
    for (int k = 0; k < 5; k++) begin
      if (stop_req_no) n++;
      @(negedge clk);
    end
    check("R2 stays negated", n, 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule